// File: doc/BRIEF.md
# CAN Low-Power Sleep and Wake Sequencer

This block sits beside a CAN controller's frame engine and handles entry into and exit from low-power operation. A control bit asks for low-power mode. The block does not cut the controller off in the middle of traffic. It first waits until the bus has been quiet for a full idle window of consecutive recessive bits, and only then raises its sleep status flag.

Clearing the control bit starts a resynchronisation. The block counts consecutive recessive bits again, and any dominant bit restarts the count. A frame that is still on the wire when the request drops is therefore skipped, and the block locks on in the next interframe gap. When the window completes, the wake status flag rises, the sleep flag drops on the same edge, and the frame engine may transmit again.

The two status flags exclude each other. The wake flag drives an interrupt line through a mask bit. The same idle window is also required once after reset, before the first transmission is allowed.

Top module: `can_lpm_seq`

## Requirements
- R1: After reset, `sleep_flag`, `wake_flag`, `irq` and `tx_ok` are all 0, and `tx_ok` stays 0 until `IDLE_BITS` (default 11) consecutive recessive bits have been sampled. It becomes 1 in the cycle after the strobe that carries the last of those bits.
- R2: A bit is counted only in a cycle where `bit_stb` is 1. `rx_bit` = 1 means recessive and `rx_bit` = 0 means dominant. A dominant bit restarts the recessive count from zero, and `rx_bit` held recessive without strobes advances nothing.
- R3: While `tx_ok` is 1, raising `lpm_req` drops `tx_ok` in the next cycle. `sleep_flag` is set only in the cycle after the strobe that completes a full window of consecutive recessive bits, counted from the request.
- R4: Setting `sleep_flag` clears `wake_flag` on the same edge, and the two flags are never 1 together.
- R5: Dropping `lpm_req` before `sleep_flag` is set cancels the entry. `tx_ok` returns to 1 in the next cycle, and `sleep_flag` stays 0 however long the bus then stays idle.
- R6: When `lpm_req` is cleared while asleep and the bus is idle, `wake_flag` and `tx_ok` become 1, and `sleep_flag` becomes 0, in the cycle after the `IDLE_BITS`-th recessive strobe.
- R7: When `lpm_req` is cleared while the bus carries a frame, every dominant bit of that frame restarts the count. `wake_flag` rises only after a full run of consecutive recessive bits that follows the last dominant bit.
- R8: `irq` is 1 exactly while `wake_flag` and `wake_ie` are both 1. `wake_flag` stays set until the next sleep entry.
- R9: `tx_ok` is 0 during the whole time `sleep_flag` is 1, and during resynchronisation until `wake_flag` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| bit_stb | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| lpm_req | input | 1 | Low-power mode request from the control register |
| wake_ie | input | 1 | Interrupt mask for the wake flag, 1 enables |
| sleep_flag | output | 1 | Status: controller is in low-power mode |
| wake_flag | output | 1 | Status: controller has resynchronised after low-power mode |
| irq | output | 1 | Wake interrupt |
| tx_ok | output | 1 | Frame engine may start a transmission |

## Verification
The embedded assertions check several properties on every cycle. They check that the two flags are exclusive and that transmission is held off while asleep. They check that the counter stays inside its window and that a sampled dominant bit empties it. They also check that every rise of `wake_flag`, `sleep_flag` or `tx_ok` follows a recessive strobe, except for a rise of `tx_ok` caused by a cancelled request. Only the directed scenarios can show that exactly `IDLE_BITS` bits are needed, that a frame in flight postpones the wake, that a cancelled entry never sleeps, and how the interrupt follows its mask.

// File: rtl/can_lpm_pkg.sv
package can_lpm_pkg;

  typedef enum logic [2:0] {
    ST_SYNC   = 3'd0,  // after reset, waiting for first idle window
    ST_RUN    = 3'd1,  // synchronised, transmission allowed
    ST_ENTER  = 3'd2,  // low-power requested, waiting for idle window
    ST_SLEEP  = 3'd3,  // low-power mode
    ST_RESYNC = 3'd4   // request dropped, waiting for idle window
  } lpm_state_t;

endpackage

// File: rtl/can_lpm_idle_cnt.sv
module can_lpm_idle_cnt #(
  parameter int IDLE_BITS = 11,
  localparam int CNT_W = $clog2(IDLE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_stb,
  input  logic             rx_bit,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  assign done   = en && bit_stb && rx_bit && (cnt_q == LAST);
  assign cnt_we = clr || (en && bit_stb);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !rx_bit || done) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(IDLE_BITS)); // R2
  AST_DOMINANT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_stb && !rx_bit) |=> (cnt_q == '0)); // R2
  AST_NO_STB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !clr) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/can_lpm_fsm.sv
module can_lpm_fsm
  import can_lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lpm_req,
  input  logic idle_done,
  output logic cnt_clr,
  output logic cnt_en,
  output logic set_sleep,
  output logic set_wake,
  output logic tx_ok
);

  lpm_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SYNC:   if (idle_done) state_d = ST_RUN;
      ST_RUN:    if (lpm_req) state_d = ST_ENTER;
      ST_ENTER:  if (!lpm_req) state_d = ST_RUN;
                 else if (idle_done) state_d = ST_SLEEP;
      ST_SLEEP:  if (!lpm_req) state_d = ST_RESYNC;
      ST_RESYNC: if (lpm_req) state_d = ST_SLEEP;
                 else if (idle_done) state_d = ST_RUN;
      default:   state_d = ST_SYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SYNC;
    else        state_q <= state_d;
  end

  assign cnt_clr   = (state_d != state_q);
  assign cnt_en    = (state_q == ST_SYNC) || (state_q == ST_ENTER) ||
                     (state_q == ST_RESYNC);
  assign set_sleep = (state_q == ST_ENTER) && lpm_req && idle_done;
  assign set_wake  = (state_q == ST_RESYNC) && !lpm_req && idle_done;
  assign tx_ok     = (state_q == ST_RUN);

  AST_TX_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ok) |-> ($past(idle_done) || !$past(lpm_req))); // R5
  AST_SLEEP_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && lpm_req) |=> (state_q == ST_SLEEP)); // R9

endmodule

// File: rtl/can_lpm_flags.sv
module can_lpm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_sleep,
  input  logic set_wake,
  input  logic wake_ie,
  output logic sleep_flag,
  output logic wake_flag,
  output logic irq
);

  logic sleep_q, sleep_d, wake_q, wake_d, flags_we;

  assign flags_we = set_sleep || set_wake;

  always_comb begin
    sleep_d = sleep_q;
    wake_d  = wake_q;
    if (set_sleep) begin
      sleep_d = 1'b1;
      wake_d  = 1'b0;
    end else if (set_wake) begin
      sleep_d = 1'b0;
      wake_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else if (flags_we) begin
      sleep_q <= sleep_d;
      wake_q  <= wake_d;
    end
  end

  assign sleep_flag = sleep_q;
  assign wake_flag  = wake_q;
  assign irq        = wake_q & wake_ie;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_q && wake_q)); // R4
  AST_SLEEP_KILLS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> !wake_q); // R4

endmodule

// File: rtl/can_lpm_seq.sv
module can_lpm_seq #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_bit,
  input  logic lpm_req,
  input  logic wake_ie,
  output logic sleep_flag,
  output logic wake_flag,
  output logic irq,
  output logic tx_ok
);

  localparam int CNT_W = $clog2(IDLE_BITS + 1);

  logic             cnt_clr, cnt_en, idle_done;
  logic             set_sleep, set_wake;
  logic [CNT_W-1:0] idle_cnt;

  can_lpm_idle_cnt #(.IDLE_BITS(IDLE_BITS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .en      (cnt_en),
    .bit_stb (bit_stb),
    .rx_bit  (rx_bit),
    .done    (idle_done),
    .cnt     (idle_cnt)
  );

  can_lpm_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lpm_req   (lpm_req),
    .idle_done (idle_done),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .set_sleep (set_sleep),
    .set_wake  (set_wake),
    .tx_ok     (tx_ok)
  );

  can_lpm_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_sleep  (set_sleep),
    .set_wake   (set_wake),
    .wake_ie    (wake_ie),
    .sleep_flag (sleep_flag),
    .wake_flag  (wake_flag),
    .irq        (irq)
  );

  AST_TX_BLOCKED_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag |-> !tx_ok); // R9
  AST_WAKE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> ($past(bit_stb && rx_bit) && $past(idle_cnt) == CNT_W'(IDLE_BITS - 1))); // R6
  AST_SLEEP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> ($past(lpm_req) && $past(bit_stb && rx_bit))); // R3
  AST_WAKE_NEEDS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> !$past(lpm_req)); // R7

endmodule

// File: tb/sim_can_lpm_seq.sv
module sim_can_lpm_seq;

  localparam int NB = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, rx_bit = 1'b1, lpm_req = 1'b0, wake_ie = 1'b0;
  logic sleep_flag, wake_flag, irq, tx_ok;
  int   n_chk = 0, n_err = 0;
  bit   done_run = 1'b0;

  always #4 clk = ~clk;

  can_lpm_seq #(.IDLE_BITS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .lpm_req(lpm_req), .wake_ie(wake_ie), .sleep_flag(sleep_flag),
    .wake_flag(wake_flag), .irq(irq), .tx_ok(tx_ok)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic bits(input int n, input logic val);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_stb = 1'b1; rx_bit = val;
      @(negedge clk); bit_stb = 1'b0; rx_bit = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk("R1", "sleep after reset", sleep_flag, 1'b0);
    chk("R1", "wake after reset", wake_flag, 1'b0);
    chk("R1", "irq after reset", irq, 1'b0);
    chk("R1", "tx_ok after reset", tx_ok, 1'b0);
  endtask

  task automatic t_first_sync;
    bits(NB - 1, 1'b1);
    bits(1, 1'b0);
    bits(NB - 1, 1'b1);
    chk("R2", "tx_ok after broken run", tx_ok, 1'b0);
    rx_bit = 1'b1;
    repeat (30) @(negedge clk);
    chk("R2", "tx_ok without strobes", tx_ok, 1'b0);
    bits(1, 1'b1);
    chk("R1", "tx_ok after full window", tx_ok, 1'b1);
    chk("R1", "wake stays clear at first sync", wake_flag, 1'b0);
  endtask

  task automatic t_enter_sleep(input logic wake_before);
    @(negedge clk); lpm_req = 1'b1;
    @(negedge clk);
    chk("R3", "tx_ok drops on request", tx_ok, 1'b0);
    bits(5, 1'b1);
    bits(1, 1'b0);
    bits(NB - 1, 1'b1);
    chk("R3", "sleep before window", sleep_flag, 1'b0);
    chk("R4", "wake held before sleep", wake_flag, wake_before);
    bits(1, 1'b1);
    chk("R3", "sleep after window", sleep_flag, 1'b1);
    chk("R4", "wake cleared by sleep", wake_flag, 1'b0);
    chk("R8", "irq cleared by sleep", irq, 1'b0);
    chk("R9", "tx_ok while asleep", tx_ok, 1'b0);
  endtask

  task automatic t_wake_idle;
    @(negedge clk); lpm_req = 1'b0;
    @(negedge clk);
    bits(NB - 1, 1'b1);
    chk("R9", "tx_ok during resync", tx_ok, 1'b0);
    chk("R6", "sleep during resync", sleep_flag, 1'b1);
    chk("R6", "wake during resync", wake_flag, 1'b0);
    bits(1, 1'b1);
    chk("R6", "wake after window", wake_flag, 1'b1);
    chk("R6", "sleep cleared by wake", sleep_flag, 1'b0);
    chk("R6", "tx_ok after wake", tx_ok, 1'b1);
    chk("R8", "irq with mask on", irq, 1'b1);
    repeat (20) @(negedge clk);
    chk("R8", "irq persists", irq, 1'b1);
    wake_ie = 1'b0;
    @(negedge clk);
    chk("R8", "irq masked", irq, 1'b0);
    chk("R8", "wake persists under mask", wake_flag, 1'b1);
    wake_ie = 1'b1;
    @(negedge clk);
    chk("R8", "irq unmasked", irq, 1'b1);
  endtask

  task automatic t_wake_busy;
    @(negedge clk); lpm_req = 1'b0;
    @(negedge clk);
    bits(3, 1'b1); bits(2, 1'b0); bits(4, 1'b1); bits(1, 1'b0);
    bits(NB - 1, 1'b1); bits(1, 1'b0);
    bits(NB - 1, 1'b1);
    chk("R7", "wake during frame", wake_flag, 1'b0);
    chk("R7", "tx_ok during frame", tx_ok, 1'b0);
    bits(1, 1'b1);
    chk("R7", "wake after interframe", wake_flag, 1'b1);
    chk("R7", "tx_ok after interframe", tx_ok, 1'b1);
  endtask

  task automatic t_cancel;
    @(negedge clk); lpm_req = 1'b1;
    bits(6, 1'b1);
    chk("R5", "tx_ok held off while entering", tx_ok, 1'b0);
    lpm_req = 1'b0;
    @(negedge clk);
    chk("R5", "tx_ok after cancel", tx_ok, 1'b1);
    bits(2 * NB, 1'b1);
    chk("R5", "sleep never set", sleep_flag, 1'b0);
    chk("R5", "wake kept after cancel", wake_flag, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_sync;
    wake_ie = 1'b1;
    t_enter_sleep(1'b0);
    t_wake_idle;
    t_enter_sleep(1'b1);
    t_wake_busy;
    t_cancel;
    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule